// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the coherence controller of one small private cache that sits on a shared bus with other caches and a memory. It serves word-sized load and store requests from its processor, holds each cached line in one of three coherence states (Invalid, Shared, Modified), and watches every transaction that other agents place on the bus. The cache is write-back and invalidation-based: a store takes ownership of the line by issuing a read-exclusive request, which removes every other copy. Only the owner of a dirty line writes it back.

The bus is atomic. The controller raises a request with a command and an address, holds it, and treats the single cycle in which the grant arrives as the whole transaction. Read data is taken from the bus in that same cycle, and write-back data is driven in it. Snooped transactions come in on a separate port. When a snooped read or read-exclusive hits a Modified line, the controller answers in the same cycle with flush data that the requester and memory both take. The processor keeps its request steady until the controller reports completion, and it issues nothing new in the meantime.

Storage is direct-mapped, with one 32-bit word per line and four lines by default. The low address bits select the line and the remaining bits form the tag.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_done`, `bus_req` and `flush_valid` are low, and the first access to each line is a miss.
- R2: A processor read that misses issues a bus read (`bus_cmd` = 2'b01) at the requested address. On grant the line is installed as Shared and the bus data is returned.
- R3: A read that hits a Shared or Modified line, or a write that hits a Modified line, completes with `cpu_done` one cycle after the request is accepted. It raises no bus request.
- R4: A write to a line that is not Modified with a matching tag (Invalid, Shared, or holding another tag) issues a read-exclusive (`bus_cmd` = 2'b10) at the write address. On grant the line becomes Modified and holds the write data.
- R5: A snooped bus read (`snp_cmd` = 2'b01) that hits a Modified line raises `flush_valid` in the same cycle with the line's data. The line becomes Shared, so a later write needs a read-exclusive again.
- R6: A snooped read-exclusive (`snp_cmd` = 2'b10) that hits a line invalidates it. If the line was Modified, its data is flushed in that same cycle first.
- R7: A miss that evicts a Modified line first issues a write-back (`bus_cmd` = 2'b11) carrying the victim's address and data. Evicting a Shared line issues no bus transaction.
- R8: A snoop whose address is not held, a snooped write-back (`snp_cmd` = 2'b11), and a snoop presented in the cycle of this cache's own grant all cause no flush and no state change.
- R9: A bus request stays asserted with a stable command until granted. A snoop in the same cycle as a new processor request is handled first, and the processor request is accepted one cycle later.
- R10: `cpu_done` is a one-cycle pulse. With it, `cpu_rdata` carries the coherent value of the read address.
- R11: If a snoop removes or downgrades the Modified victim while its write-back is still waiting for a grant, the write-back is dropped. Only the fill request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address of the request |
| cpu_wdata | input | DW | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load result, valid with `cpu_done` |
| bus_req | output | 1 | Bus request, held until granted |
| bus_cmd | output | 2 | 01 read, 10 read-exclusive, 11 write-back |
| bus_addr | output | AW | Word address of the bus request |
| bus_wdata | output | DW | Write-back data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DW | Fill data, sampled in the grant cycle |
| snp_valid | input | 1 | A bus transaction is being snooped |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped word address |
| flush_valid | output | 1 | This cache supplies the snooped line this cycle |
| flush_data | output | DW | Flushed data |

## Verification
The hardest case to reach is a snooped read-exclusive that lands on the dirty victim while this cache's own write-back is still waiting for the bus. The bench reaches it by dirtying a line and starting a conflicting read. It then withholds the grant from its bus model for a few cycles and injects the snoop in that window. After that it checks that only the fill is granted and that the flushed data matches. Random mixed sweeps over three tags on every line also exercise the other paths. They vary grant delay, and they sometimes echo the cache's own transaction onto the snoop port in its grant cycle. A reference model in the bench predicts the bus traffic, the flushes and the returned data.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'b00,
        LS_S = 2'b01,
        LS_M = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'b00,
        BC_RD   = 2'b01,
        BC_RDX  = 2'b10,
        BC_WB   = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'b00,
        PS_WB   = 2'b01,
        PS_FILL = 2'b10
    } proc_st_e;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data
);

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g]   <= LS_I;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (sel) begin
                st_q[g]   <= wr_st;
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              bus_gnt,
    input  line_st_e          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output line_st_e          upd_st,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);

    logic live;
    logic hit;
    logic dirty;

    // A snoop in our own grant cycle is our own transaction: ignore it.
    assign live  = snp_valid && !bus_gnt;
    assign hit   = live && (line_st != LS_I) && (line_tag == snp_tag);
    assign dirty = hit && (line_st == LS_M);

    always_comb begin
        upd_en      = 1'b0;
        upd_st      = line_st;
        flush_valid = 1'b0;
        flush_data  = '0;
        unique case (snp_cmd)
            BC_RD: begin
                if (dirty) begin
                    upd_en      = 1'b1;
                    upd_st      = LS_S;
                    flush_valid = 1'b1;
                    flush_data  = line_data;
                end
            end
            BC_RDX: begin
                if (hit) begin
                    upd_en = 1'b1;
                    upd_st = LS_I;
                end
                if (dirty) begin
                    flush_valid = 1'b1;
                    flush_data  = line_data;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = AW - IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          flush_valid,
    output logic [DW-1:0] flush_data
);

    typedef struct packed {
        proc_st_e      st;
        logic [AW-1:0] addr;
        logic          we;
        logic [DW-1:0] wdata;
        logic          done;
        logic [DW-1:0] rdata;
    } ctrl_t;

    ctrl_t q, n;

    // line store ports
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_e          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DW-1:0]     wr_data;
    line_st_e          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DW-1:0]     a_data, b_data;

    // snoop unit outputs
    logic              snp_upd;
    line_st_e          snp_new_st;

    logic [AW-1:0]     cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic              tag_match;

    assign cur_addr  = (q.st == PS_IDLE) ? cpu_addr : q.addr;
    assign cur_idx   = cur_addr[IDX_W-1:0];
    assign cur_tag   = cur_addr[AW-1:IDX_W];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[AW-1:IDX_W];
    assign tag_match = (a_st != LS_I) && (a_tag == cur_tag);

    msi_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_st   (wr_st),
        .wr_tag  (wr_tag),
        .wr_data (wr_data),
        .a_idx   (cur_idx),
        .a_st    (a_st),
        .a_tag   (a_tag),
        .a_data  (a_data),
        .b_idx   (snp_idx),
        .b_st    (b_st),
        .b_tag   (b_tag),
        .b_data  (b_data)
    );

    msi_snoop_unit #(
        .TAG_W  (TAG_W),
        .DATA_W (DW)
    ) u_snoop (
        .snp_valid   (snp_valid),
        .snp_cmd     (snp_cmd),
        .snp_tag     (snp_tag),
        .bus_gnt     (bus_gnt),
        .line_st     (b_st),
        .line_tag    (b_tag),
        .line_data   (b_data),
        .upd_en      (snp_upd),
        .upd_st      (snp_new_st),
        .flush_valid (flush_valid),
        .flush_data  (flush_data)
    );

    always_comb begin
        n      = q;
        n.done = 1'b0;

        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;

        // Snoop updates: only when no processor write can happen this cycle.
        wr_en   = snp_upd;
        wr_idx  = snp_idx;
        wr_st   = snp_new_st;
        wr_tag  = b_tag;
        wr_data = b_data;

        unique case (q.st)
            PS_IDLE: begin
                // Snoop has priority: a new request waits one cycle.
                if (cpu_req && !snp_valid) begin
                    n.addr  = cpu_addr;
                    n.we    = cpu_we;
                    n.wdata = cpu_wdata;
                    if (tag_match && !cpu_we) begin
                        n.done  = 1'b1;
                        n.rdata = a_data;
                    end else if (tag_match && cpu_we && (a_st == LS_M)) begin
                        wr_en   = 1'b1;
                        wr_idx  = cur_idx;
                        wr_st   = LS_M;
                        wr_tag  = cur_tag;
                        wr_data = cpu_wdata;
                        n.done  = 1'b1;
                        n.rdata = cpu_wdata;
                    end else if (a_st == LS_M) begin
                        n.st = PS_WB;
                    end else begin
                        n.st = PS_FILL;
                    end
                end
            end
            PS_WB: begin
                if ((a_st == LS_M) && (a_tag != cur_tag)) begin
                    bus_req   = 1'b1;
                    bus_cmd   = BC_WB;
                    bus_addr  = {a_tag, cur_idx};
                    bus_wdata = a_data;
                    if (bus_gnt) begin
                        wr_en   = 1'b1;
                        wr_idx  = cur_idx;
                        wr_st   = LS_I;
                        wr_tag  = a_tag;
                        wr_data = a_data;
                        n.st    = PS_FILL;
                    end
                end else begin
                    // Victim was taken by a snoop while waiting.
                    n.st = PS_FILL;
                end
            end
            PS_FILL: begin
                bus_req  = 1'b1;
                bus_cmd  = q.we ? BC_RDX : BC_RD;
                bus_addr = q.addr;
                if (bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_idx  = cur_idx;
                    wr_st   = q.we ? LS_M : LS_S;
                    wr_tag  = cur_tag;
                    wr_data = q.we ? q.wdata : bus_rdata;
                    n.rdata = q.we ? q.wdata : bus_rdata;
                    n.done  = 1'b1;
                    n.st    = PS_IDLE;
                end
            end
            default: n.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign cpu_done  = q.done;
    assign cpu_rdata = q.rdata;

endmodule

// File: rtl/msi_cache_chk.sv
module msi_cache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_done,
    input logic       bus_req,
    input logic [1:0] bus_cmd,
    input logic       bus_gnt,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       flush_valid
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_cmd)));

    // R5 R6
    flush_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (snp_valid && (snp_cmd == 2'b01 || snp_cmd == 2'b10)));

    // R8
    own_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> !flush_valid);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req);

    // R2 R4 R7
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 2'b00));

endmodule

bind msi_cache_ctrl msi_cache_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_done    (cpu_done),
    .bus_req     (bus_req),
    .bus_cmd     (bus_cmd),
    .bus_gnt     (bus_gnt),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .flush_valid (flush_valid)
);

// File: tb/msi_cache_ctrl_bench.sv
`timescale 1ns/1ps
module msi_cache_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic [31:0] bus_rdata;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        flush_valid;
    logic [31:0] flush_data;

    logic [31:0] mem   [256];
    logic [31:0] truth [256];
    int          m_st  [4];     // 0 Invalid, 1 Shared, 2 Modified
    logic [5:0]  m_tag [4];

    logic [1:0]  tr_cmd  [4];
    logic [7:0]  tr_addr [4];
    logic [31:0] tr_data [4];
    int          tr_cnt = 0;

    int  nchk = 0, nerr = 0, cyc = 0;
    int  wait_left = 0, gnt_delay = 0;
    bit  hold = 0, echo_on = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    assign bus_rdata = mem[bus_addr];

    msi_cache_ctrl u_msi_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .flush_valid(flush_valid), .flush_data(flush_data)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {17'd0, seed[30:16]};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    // Bus model: grants after a delay; the transaction is atomic in the grant cycle.
    always @(negedge clk) begin
        if (bus_gnt) begin
            bus_gnt = 1'b0;
            if (echo_on) snp_valid = 1'b0;
        end else if (bus_req && !hold && !snp_valid) begin
            if (wait_left > 0) begin
                wait_left--;
            end else begin
                bus_gnt = 1'b1;
                if (tr_cnt < 4) begin
                    tr_cmd[tr_cnt]  = bus_cmd;
                    tr_addr[tr_cnt] = bus_addr;
                    tr_data[tr_cnt] = bus_wdata;
                end
                tr_cnt++;
                if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
                wait_left = gnt_delay;
                if (echo_on) begin
                    snp_valid = 1'b1;
                    snp_cmd   = bus_cmd;
                    snp_addr  = bus_addr;
                    #1;
                    chk(!flush_valid, "R8", "flush on own echoed transaction", 32'(flush_valid), 0);
                end
            end
        end
    end

    task automatic do_cpu(bit we, logic [7:0] a, logic [31:0] d, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        tr_cnt = 0; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_done && lat < 200);
        cpu_req = 1'b0;
    endtask

    task automatic cpu_checked(bit we, logic [7:0] a, logic [31:0] d);
        int idx = int'(a[1:0]);
        logic [5:0] tg = a[7:2];
        bit tm  = (m_st[idx] != 0) && (m_tag[idx] == tg);
        bit wbn = (m_st[idx] == 2) && (m_tag[idx] != tg);
        bit miss = we ? !(tm && m_st[idx] == 2) : !tm;
        int en = int'(wbn) + int'(miss);
        int lat, k;
        logic [7:0] va = {m_tag[idx], a[1:0]};
        wait_left = gnt_delay;
        do_cpu(we, a, d, lat);
        chk(lat < 200, "R10", "completion", lat, 0);
        chk(tr_cnt == en, we ? "R4" : "R2", "bus transaction count", tr_cnt, en);
        if (tr_cnt == en) begin
            k = 0;
            if (wbn) begin
                chk(tr_cmd[0] == 2'b11 && tr_addr[0] == va, "R7", "write-back cmd/addr",
                    {22'd0, tr_cmd[0], tr_addr[0]}, {22'd0, 2'b11, va});
                chk(tr_data[0] == truth[va], "R7", "write-back data", tr_data[0], truth[va]);
                k = 1;
            end
            if (miss)
                chk(tr_cmd[k] == (we ? 2'b10 : 2'b01) && tr_addr[k] == a, we ? "R4" : "R2",
                    "fill cmd/addr", {22'd0, tr_cmd[k], tr_addr[k]},
                    {22'd0, (we ? 2'b10 : 2'b01), a});
        end
        if (!miss) chk(lat == 1, "R3", "hit latency", lat, 1);
        if (!we) chk(cpu_rdata == truth[a], "R10", "read data", cpu_rdata, truth[a]);
        if (miss) begin
            m_st[idx]  = we ? 2 : 1;
            m_tag[idx] = tg;
        end
        if (we) truth[a] = d;
    endtask

    task automatic snoop_checked(bit rdx, logic [7:0] a);
        int idx = int'(a[1:0]);
        bit tm = (m_st[idx] != 0) && (m_tag[idx] == a[7:2]);
        bit exp_fl = tm && (m_st[idx] == 2);
        string req = tm ? (rdx ? "R6" : "R5") : "R8";
        logic fv;
        logic [31:0] fd, v;
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = rdx ? 2'b10 : 2'b01; snp_addr = a;
        #1;
        fv = flush_valid; fd = flush_data;
        chk(fv == exp_fl, req, "flush_valid", 32'(fv), 32'(exp_fl));
        if (fv && exp_fl) chk(fd == truth[a], req, "flush data", fd, truth[a]);
        if (fv) mem[a] = fd;
        @(negedge clk);
        snp_valid = 1'b0;
        if (tm) m_st[idx] = rdx ? 0 : ((m_st[idx] == 2) ? 1 : m_st[idx]);
        if (rdx) begin
            v = rnd() ^ 32'hA5A5_0000;
            truth[a] = v;
            mem[a]   = v;
        end
    endtask

    initial begin
        int lat;
        logic fv;
        logic [31:0] fd;
        for (int i = 0; i < 256; i++) begin
            mem[i]   = 32'(i) * 32'd7 + 32'd3;
            truth[i] = mem[i];
        end
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 0; m_tag[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet outputs after reset
        chk(!cpu_done, "R1", "cpu_done after reset", 32'(cpu_done), 0);
        chk(!bus_req, "R1", "bus_req after reset", 32'(bus_req), 0);
        chk(!flush_valid, "R1", "flush_valid after reset", 32'(flush_valid), 0);

        // R9: snoop to an absent line at the same time as a new request
        cpu_checked(0, 8'h00, 0);
        chk(tr_cnt == 1, "R1", "first access misses", tr_cnt, 1);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h00;
        snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = 8'h05;
        #1;
        chk(!flush_valid, "R8", "flush for absent line", 32'(flush_valid), 0);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(!cpu_done, "R9", "request held back by snoop", 32'(cpu_done), 0);
        @(negedge clk);
        chk(cpu_done, "R9", "request accepted after snoop", 32'(cpu_done), 1);
        cpu_req = 1'b0;

        // R1: every other line misses first
        for (int i = 1; i < 4; i++) begin
            cpu_checked(0, 8'(i), 0);
            chk(tr_cnt == 1, "R1", "first access misses", tr_cnt, 1);
        end

        // R8: snooped write-back has no effect on a held dirty line
        cpu_checked(1, 8'h01, 32'hCAFE_0001);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'b11; snp_addr = 8'h01;
        #1;
        chk(!flush_valid, "R8", "flush on snooped write-back", 32'(flush_valid), 0);
        @(negedge clk);
        snp_valid = 1'b0;
        cpu_checked(1, 8'h01, 32'hCAFE_0002);   // must still be a Modified hit

        // R11: snoop takes the dirty victim while its write-back waits
        cpu_checked(1, 8'h02, 32'hBEEF_0002);
        gnt_delay = 0; wait_left = 0; hold = 1;
        fork
            do_cpu(0, 8'h06, 0, lat);
            begin
                repeat (3) @(negedge clk);
                snp_valid = 1'b1; snp_cmd = 2'b10; snp_addr = 8'h02;
                #1;
                fv = flush_valid; fd = flush_data;
                @(negedge clk);
                snp_valid = 1'b0;
                hold = 0;
            end
        join
        chk(fv, "R6", "flush of dirty victim", 32'(fv), 1);
        chk(fd == 32'hBEEF_0002, "R6", "victim flush data", fd, 32'hBEEF_0002);
        mem[2] = fd;
        chk(tr_cnt == 1, "R11", "only the fill is issued", tr_cnt, 1);
        chk(tr_cmd[0] == 2'b01 && tr_addr[0] == 8'h06, "R11", "fill cmd/addr",
            {22'd0, tr_cmd[0], tr_addr[0]}, {22'd0, 2'b01, 8'h06});
        chk(cpu_rdata == truth[6], "R10", "read data after dropped write-back", cpu_rdata, truth[6]);
        m_st[2] = 1; m_tag[2] = 6'd1;

        // Mixed sweep over every line, three tags, varying grant delay
        for (int it = 0; it < 700; it++) begin
            logic [31:0] r = rnd();
            int op = int'(r % 6);
            int t = int'((r >> 4) % 3);
            logic [7:0] a = {(t == 2) ? 6'd3 : 6'(t), r[9:8]};
            gnt_delay = int'((r >> 10) % 3);
            echo_on = r[12];
            case (op)
                0, 1: cpu_checked(0, a, 0);
                2, 3: cpu_checked(1, a, rnd() ^ 32'h5A00_0000);
                4:    snoop_checked(0, a);
                default: snoop_checked(1, a);
            endcase
            echo_on = 0;
        end

        repeat (2) @(negedge clk);
        summary();
    end

endmodule